// File: doc/BRIEF.md
# Packed Signed Byte Maximum Unit

This block is a SIMD datapath stage that takes two 256-bit operand vectors, treats each as 32 independent two's-complement bytes, and returns the larger byte of every lane pair. It also receives the current value of the destination register. That value is needed because one of the narrow modes leaves the upper half of the destination untouched.

A two-bit mode input picks the operation width and how the upper 128 bits are treated. In the narrow merge form those bits come from the old destination. In the narrow clearing form they are forced to zero. In the wide form all 32 lanes are computed. The fourth mode code is an illegal encoding: instead of a result, it raises an undefined-operation fault.

Every accepted request produces its registered outputs exactly one clock later. Operand fetch, decode, register write-back and fault delivery all live outside the block.

Top module: `packed_smax_unit`

## Requirements
- R1: Each byte lane is compared as a signed two's-complement value, so 0x7F beats 0x80 and 0x00 beats 0xFF.
- R2: In a lane, the src1 byte is chosen only if it is strictly greater than the src2 byte; otherwise, including equality, the src2 byte is chosen.
- R3: In mode 0 (narrow merge) and mode 1 (narrow clear), result bits 127:0 hold the lane maxima of lanes 0 to 15.
- R4: In mode 0, result bits 255:128 equal dest_prev bits 255:128 as sampled with the request.
- R5: In mode 1, result bits 255:128 are all zero.
- R6: In mode 2 (wide), all 32 lanes, bits 255:0, are computed by the rule of R1 and R2.
- R7: A request with mode 3 raises ud_fault for one cycle, keeps out_valid low and leaves result unchanged.
- R8: For a legal request, result and out_valid appear one clock after in_valid. A cycle without in_valid gives out_valid and ud_fault low on the next clock, and result holds its value.
- R9: While rst_n is low at a clock edge, result, out_valid and ud_fault are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| mode | input | 2 | 0 narrow merge, 1 narrow clear, 2 wide, 3 illegal |
| src1 | input | 256 | First operand vector |
| src2 | input | 256 | Second operand vector |
| dest_prev | input | 256 | Current destination register contents |
| result | output | 256 | Registered lane-wise maximum |
| out_valid | output | 1 | Result valid, one clock after the request |
| ud_fault | output | 1 | Undefined-operation fault for mode 3 |

## Verification
Directed vectors pair -128 with 127 in both operand orders. They catch an unsigned compare, which would pick 0x80, and a swapped select. A pair of 0 against -1 catches a sign-bit compare that is wrong only near zero. Equal bytes confirm that tie-breaking leaves the byte unchanged.

Random vectors in every mode, each with a distinct dest_prev, tell the three upper-half treatments apart. Mode 3 requests and idle gaps placed between them show that result holds its value and that the two strobes never overlap.

// File: rtl/smax_pkg.sv
// Shared types for the packed signed byte maximum unit.
// Assumes mode codes are fixed by the surrounding decode logic.
package smax_pkg;
    typedef enum logic [1:0] {
        VM_NARROW_KEEP  = 2'd0,
        VM_NARROW_CLEAR = 2'd1,
        VM_WIDE         = 2'd2,
        VM_ILLEGAL      = 2'd3
    } vmode_e;
endpackage

// File: rtl/smax_lane.sv
// One lane: picks the signed maximum of two bytes; ties go to operand b.
// Assumes both inputs are two's-complement values of width W.
module smax_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    // Strict signed compare; equality falls through to b.
    always_comb begin
        y = ($signed(a) > $signed(b)) ? a : b;
    end

    // The chosen value is one of the inputs and dominates both (R1, R2).
    always_comb begin
        assert_lane_max_R1: assert (($signed(y) >= $signed(a)) && ($signed(y) >= $signed(b)))
            else $error("lane output not the signed maximum");
        assert_lane_pick_R2: assert ((y == a) || (y == b))
            else $error("lane output is neither input");
    end
endmodule

// File: rtl/smax_array.sv
// Replicates the lane comparator across the whole vector.
// Assumes lane i occupies bits [i*W +: W] of each operand.
module smax_array #(
    parameter int W     = 8,
    parameter int LANES = 32,
    localparam int VW   = W * LANES
) (
    input  logic [VW-1:0] a,
    input  logic [VW-1:0] b,
    output logic [VW-1:0] y
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        smax_lane #(.W(W)) lane_i (
            .a(a[i*W +: W]),
            .b(b[i*W +: W]),
            .y(y[i*W +: W])
        );
    end
endmodule

// File: rtl/smax_hi_sel.sv
// Chooses the upper half of the result from the mode: old destination,
// zeros or the computed maxima. Assumes the illegal code is filtered upstream.
module smax_hi_sel #(
    parameter int HW = 128
) (
    input  smax_pkg::vmode_e mode,
    input  logic [HW-1:0]    computed,
    input  logic [HW-1:0]    old_dest,
    output logic [HW-1:0]    hi
);
    import smax_pkg::*;

    // Upper-half source multiplexer.
    always_comb begin
        unique case (mode)
            VM_NARROW_KEEP:  hi = old_dest;
            VM_NARROW_CLEAR: hi = '0;
            VM_WIDE:         hi = computed;
            default:         hi = '0;
        endcase
    end
endmodule

// File: rtl/packed_smax_unit.sv
// Packed signed byte maximum with three width/merge modes and a fault on
// the illegal mode code. One registered stage; synchronous active-low reset.
// Assumes inputs are stable around the rising clock edge.
module packed_smax_unit #(
    parameter int LANE_W = 8,
    parameter int LANES  = 32,
    localparam int VW    = LANE_W * LANES,
    localparam int HW    = VW / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [1:0]    mode,
    input  logic [VW-1:0] src1,
    input  logic [VW-1:0] src2,
    input  logic [VW-1:0] dest_prev,
    output logic [VW-1:0] result,
    output logic          out_valid,
    output logic          ud_fault
);
    import smax_pkg::*;

    vmode_e        mode_e;
    logic          legal;
    logic [VW-1:0] lane_max;
    logic [HW-1:0] upper;

    // Mode decode and legality.
    always_comb begin
        mode_e = vmode_e'(mode);
        legal  = (mode_e != VM_ILLEGAL);
    end

    smax_array #(.W(LANE_W), .LANES(LANES)) array_i (
        .a(src1), .b(src2), .y(lane_max)
    );

    smax_hi_sel #(.HW(HW)) hi_i (
        .mode(mode_e), .computed(lane_max[VW-1:HW]),
        .old_dest(dest_prev[VW-1:HW]), .hi(upper)
    );

    // Output stage: capture a legal result, or flag a fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            out_valid <= 1'b0;
            ud_fault  <= 1'b0;
        end else begin
            out_valid <= in_valid && legal;
            ud_fault  <= in_valid && !legal;
            if (in_valid && legal) result <= {upper, lane_max[HW-1:0]};
        end
    end

    assert_fault_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd3) |=> (ud_fault && !out_valid && $stable(result)));
    assert_legal_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode != 2'd3) |=> (out_valid && !ud_fault));
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !ud_fault && $stable(result)));
    assert_keep_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd0) |=> (result[VW-1:HW] == $past(dest_prev[VW-1:HW])));
    assert_clear_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd1) |=> (result[VW-1:HW] == '0));
    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && ud_fault));
endmodule

// File: tb/packed_smax_unit_tb_top.sv
module packed_smax_unit_tb_top;
    localparam int VW = 256;
    localparam int HW = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic [VW-1:0] src1 = '0, src2 = '0, dest_prev = '0;
    logic [VW-1:0] result;
    logic          out_valid, ud_fault;

    int n_checks = 0;
    int n_fail   = 0;
    bit checking = 1'b0;
    string lo_tag = "R3";

    // Reference model state.
    logic [VW-1:0] m_res = '0;
    logic          m_valid = 1'b0, m_fault = 1'b0;
    string         m_lo_tag = "R8", m_hi_tag = "R8";

    always #2.5 clk = ~clk;

    packed_smax_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .src1(src1), .src2(src2), .dest_prev(dest_prev),
        .result(result), .out_valid(out_valid), .ud_fault(ud_fault)
    );

    function automatic logic [VW-1:0] ref_max(input logic [VW-1:0] a,
                                              input logic [VW-1:0] b,
                                              input int nlanes);
        logic [VW-1:0] r = '0;
        for (int i = 0; i < nlanes; i++) begin
            int x = $signed(a[i*8 +: 8]);
            int z = $signed(b[i*8 +: 8]);
            r[i*8 +: 8] = (x > z) ? a[i*8 +: 8] : b[i*8 +: 8];
        end
        return r;
    endfunction

    function automatic logic [VW-1:0] rnd256();
        logic [VW-1:0] v;
        for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom();
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [VW-1:0] act,
                         input logic [VW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural model, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_res = '0; m_valid = 0; m_fault = 0;
            m_lo_tag = "R9"; m_hi_tag = "R9";
        end else if (in_valid && mode != 2'd3) begin
            logic [VW-1:0] full;
            full = ref_max(src1, src2, 32);
            m_valid = 1; m_fault = 0;
            m_res[HW-1:0] = full[HW-1:0];
            m_lo_tag = (mode == 2'd2) ? "R6" : lo_tag;
            case (mode)
                2'd0: begin m_res[VW-1:HW] = dest_prev[VW-1:HW]; m_hi_tag = "R4"; end
                2'd1: begin m_res[VW-1:HW] = '0; m_hi_tag = "R5"; end
                default: begin m_res[VW-1:HW] = full[VW-1:HW]; m_hi_tag = "R6"; end
            endcase
        end else if (in_valid) begin
            m_valid = 0; m_fault = 1; m_lo_tag = "R7"; m_hi_tag = "R7";
        end else begin
            m_valid = 0; m_fault = 0; m_lo_tag = "R8"; m_hi_tag = "R8";
        end
    end

    // Compare against the model away from the active edge.
    always @(negedge clk) begin
        if (checking) begin
            check(result[HW-1:0] == m_res[HW-1:0], {m_lo_tag, " lower half"},
                  result, m_res);
            check(result[VW-1:HW] == m_res[VW-1:HW], {m_hi_tag, " upper half"},
                  result, m_res);
            check(out_valid == m_valid, "R8 out_valid", VW'(out_valid), VW'(m_valid));
            check(ud_fault == m_fault, "R7 ud_fault", VW'(ud_fault), VW'(m_fault));
        end
    end

    task automatic req(input logic [1:0] m, input logic [VW-1:0] a,
                       input logic [VW-1:0] b, input logic [VW-1:0] d);
        @(negedge clk);
        in_valid = 1; mode = m; src1 = a; src2 = b; dest_prev = d;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 0; src1 = rnd256(); src2 = rnd256(); dest_prev = rnd256();
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [VW-1:0] d0;
        d0 = {32{8'hA5}};
        repeat (3) @(negedge clk);
        // R9: reset state
        check(result == '0, "R9 result", result, '0);
        check(!out_valid && !ud_fault, "R9 strobes",
              VW'({out_valid, ud_fault}), '0);
        rst_n = 1;
        checking = 1;

        // R1: -128 against 127 in both orders, 0 against -1
        lo_tag = "R1";
        req(2'd2, {32{8'h80}}, {32{8'h7F}}, d0);
        req(2'd2, {32{8'h7F}}, {32{8'h80}}, d0);
        req(2'd0, {32{8'h00}}, {32{8'hFF}}, d0);
        req(2'd1, {32{8'hFF}}, {32{8'h00}}, d0);
        // R2: equal values, and strict-greater picks src1
        lo_tag = "R2";
        req(2'd2, {32{8'h33}}, {32{8'h33}}, d0);
        req(2'd0, {16{8'h05, 8'h04}}, {16{8'h04, 8'h05}}, d0);
        idle();
        // R7: illegal mode between legal requests leaves result held
        req(2'd3, rnd256(), rnd256(), rnd256());
        req(2'd3, rnd256(), rnd256(), rnd256());
        idle();

        // R3..R6: random vectors in every mode, with gaps
        lo_tag = "R3";
        for (int k = 0; k < 400; k++) begin
            int sel = $urandom_range(0, 9);
            if (sel < 3) req(2'd0, rnd256(), rnd256(), rnd256());
            else if (sel < 5) req(2'd1, rnd256(), rnd256(), rnd256());
            else if (sel < 8) req(2'd2, rnd256(), rnd256(), rnd256());
            else if (sel < 9) req(2'd3, rnd256(), rnd256(), rnd256());
            else idle();
        end
        idle();
        @(negedge clk);
        // R9: reset mid-stream clears everything
        rst_n = 0;
        @(negedge clk);
        checking = 0;
        check(result == '0 && !out_valid && !ud_fault, "R9 mid-run reset",
              result, '0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule